// File: doc/BRIEF.md
# Seven-Segment Digit Decoder with Zero Suppression

This block converts one binary-coded decimal digit (weights 8-4-2-1, valid codes 0 to 9) into seven segment drives for a common-anode display. A segment lights when its drive is low. The logic is purely combinational, so an output follows its inputs within the same cycle.

Three active-low controls sit on top of plain decoding:
- **Lamp test** lights every segment, so the display shows an eight.
- **Blank input** switches the whole display off. It overrides everything else.
- **Ripple-blank input** works with the ripple-blank output to suppress leading zeros. When it is low and the digit is zero, the display goes dark and the ripple-blank output goes low.

To suppress leading zeros across a row of digits, connect the digits from the most significant one down. Tie the first ripple-blank input low, and feed each ripple-blank output into the ripple-blank input of the next less significant digit. The least significant digit normally keeps its ripple-blank input high, so a lone zero still shows.

Top module: `bcd_seg_decoder`

## Requirements
- R1: `segN` carries segment a on bit 0 through segment g on bit 6, all active low. With the three controls high, these digits light these segments: 0 lights a,b,c,d,e,f. 1 lights b,c. 2 lights a,b,d,e,g. 3 lights a,b,c,d,g. 4 lights b,c,f,g. 5 lights a,c,d,f,g. 6 lights a,c,d,e,f,g. 7 lights a,b,c. 8 lights all seven. 9 lights a,b,c,d,f,g.
- R2: Codes 10 to 15 give fixed patterns and no fault. 10 lights d,e,g. 11 lights c,d,g. 12 lights b,f,g. 13 lights a,d,f,g. 14 lights d,e,f,g. 15 lights nothing.
- R3: When `lampTestN` is low and `blankInN` is high, `segN` is 7'b0000000 for any digit and any `rippleInN`.
- R4: When `rippleInN` is low, the digit is 0, and `lampTestN` and `blankInN` are both high, `segN` is 7'b1111111.
- R5: `rippleOutN` is low only when `rippleInN` is low, the digit is 0 and `lampTestN` is high. In every other case it is high, whatever `blankInN` is.
- R6: A nonzero digit with `rippleInN` low shows the same pattern as with `rippleInN` high.
- R7: When `blankInN` is low, `segN` is 7'b1111111 for any digit, lamp test or ripple state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digit | input | 4 | BCD code, weights 8-4-2-1 |
| lampTestN | input | 1 | Lights all segments when low |
| rippleInN | input | 1 | Enables zero suppression when low |
| blankInN | input | 1 | Turns the display off when low |
| segN | output | 7 | Segment drives, bit 0 = a to bit 6 = g, low lights the segment |
| rippleOutN | output | 1 | Low when this digit suppressed a zero |

## Verification
The block holds no state, so an internal fault shows at the ports in the same cycle as the input that triggers it:
- A wrong pattern or a wrong bit order shows as a mismatch on `segN`.
- A wrong priority among the controls shows as a lit or dark display in the cases that combine them.
- A broken ripple-blank handshake shows on `rippleOutN` at once. Further down a chain it appears as a leading zero that is shown or a middle zero that is dropped.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_N   = 7;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic forceOff;
    logic forceOn;
  } segStrobe_t;

  // Active-high lit pattern, bit 0 = a ... bit 6 = g
  function automatic logic [SEG_N-1:0] litPattern(input logic [DIGIT_W-1:0] d);
    logic [SEG_N-1:0] p;
    case (d)
      4'd0:    p = 7'b0111111;
      4'd1:    p = 7'b0000110;
      4'd2:    p = 7'b1011011;
      4'd3:    p = 7'b1001111;
      4'd4:    p = 7'b1100110;
      4'd5:    p = 7'b1101101;
      4'd6:    p = 7'b1111101;
      4'd7:    p = 7'b0000111;
      4'd8:    p = 7'b1111111;
      4'd9:    p = 7'b1101111;
      4'd10:   p = 7'b1011000;
      4'd11:   p = 7'b1001100;
      4'd12:   p = 7'b1100010;
      4'd13:   p = 7'b1101001;
      4'd14:   p = 7'b1111000;
      default: p = 7'b0000000;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/bcd_seg_ctrl.sv
module bcd_seg_ctrl
  import bcd_seg_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  input  logic               lampTestN,
  input  logic               rippleInN,
  input  logic               blankInN,
  output segStrobe_t         strobe,
  output logic               rippleOutN
);
  logic isZero;
  logic zeroSuppress;

  always_comb begin
    isZero       = (digit == '0);
    zeroSuppress = !rippleInN && isZero && lampTestN;
    // Priority: external blank, then lamp test, then ripple blanking
    strobe.forceOff = !blankInN || zeroSuppress;
    strobe.forceOn  = blankInN && !lampTestN;
    rippleOutN      = !zeroSuppress;
  end
endmodule

// File: rtl/bcd_seg_path.sv
module bcd_seg_path
  import bcd_seg_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  input  segStrobe_t         strobe,
  output logic [SEG_N-1:0]   segN
);
  logic [SEG_N-1:0] lit;

  always_comb lit = litPattern(digit);

  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    always_comb begin
      if (strobe.forceOff)     segN[s] = 1'b1;
      else if (strobe.forceOn) segN[s] = 1'b0;
      else                     segN[s] = !lit[s];
    end
  end
endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import bcd_seg_pkg::*;
(
  input  logic [3:0] digit,
  input  logic       lampTestN,
  input  logic       rippleInN,
  input  logic       blankInN,
  output logic [6:0] segN,
  output logic       rippleOutN
);
  segStrobe_t strobe;

  bcd_seg_ctrl ctrl_i (
    .digit      (digit),
    .lampTestN  (lampTestN),
    .rippleInN  (rippleInN),
    .blankInN   (blankInN),
    .strobe     (strobe),
    .rippleOutN (rippleOutN)
  );

  bcd_seg_path path_i (
    .digit  (digit),
    .strobe (strobe),
    .segN   (segN)
  );
endmodule

// File: rtl/bcd_seg_decoder_chk.sv
module bcd_seg_decoder_chk (
  input logic [3:0] digit,
  input logic       lampTestN,
  input logic       rippleInN,
  input logic       blankInN,
  input logic [6:0] segN,
  input logic       rippleOutN
);
  always_comb begin
    p_blank_all_r7: assert (blankInN || segN == 7'h7F);
    p_lamp_test_r3: assert (!blankInN || lampTestN || segN == 7'h00);
    p_zero_dark_r4: assert (!(blankInN && lampTestN && !rippleInN && digit == 4'd0)
                            || segN == 7'h7F);
    p_ripple_out_r5: assert (rippleOutN || (!rippleInN && digit == 4'd0 && lampTestN));
    p_nonzero_lit_r6: assert (!(blankInN && lampTestN && digit != 4'd0 && digit != 4'd15)
                              || segN != 7'h7F);
  end
endmodule

bind bcd_seg_decoder bcd_seg_decoder_chk chk_i (
  .digit      (digit),
  .lampTestN  (lampTestN),
  .rippleInN  (rippleInN),
  .blankInN   (blankInN),
  .segN       (segN),
  .rippleOutN (rippleOutN)
);

// File: tb/bcd_seg_decoder_tb_top.sv
module bcd_seg_decoder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = !clk;

  logic [3:0] digit = 4'd0;
  logic lampTestN = 1'b1, rippleInN = 1'b1, blankInN = 1'b1;
  logic [6:0] segN;
  logic rippleOutN;

  bcd_seg_decoder dut_i (
    .digit(digit), .lampTestN(lampTestN), .rippleInN(rippleInN),
    .blankInN(blankInN), .segN(segN), .rippleOutN(rippleOutN)
  );

  typedef struct {
    logic [6:0] seg;
    logic       rbo;
    string      req;
  } expItem_t;

  expItem_t sbQ[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Lit segments per the requirement tables, bit 0 = a
  function automatic logic [6:0] refLit(input logic [3:0] d);
    logic [6:0] m;
    case (d)
      0: m = 7'h3F;  1: m = 7'h06;  2: m = 7'h5B;  3: m = 7'h4F;
      4: m = 7'h66;  5: m = 7'h6D;  6: m = 7'h7D;  7: m = 7'h07;
      8: m = 7'h7F;  9: m = 7'h6F;  10: m = 7'h58; 11: m = 7'h4C;
      12: m = 7'h62; 13: m = 7'h69; 14: m = 7'h78; default: m = 7'h00;
    endcase
    return m;
  endfunction

  task automatic drive(input logic [3:0] d, input logic lt, input logic rbi,
                       input logic bi, input string req);
    expItem_t e;
    @(posedge clk);
    digit = d; lampTestN = lt; rippleInN = rbi; blankInN = bi;
    e.rbo = !(!rbi && d == 0 && lt);
    if (!bi)                 e.seg = 7'h7F;
    else if (!lt)            e.seg = 7'h00;
    else if (!rbi && d == 0) e.seg = 7'h7F;
    else                     e.seg = ~refLit(d);
    e.req = req;
    sbQ.push_back(e);
  endtask

  // Monitor: compare on the falling edge after each drive
  always @(negedge clk) begin
    if (rstN && sbQ.size() > 0) begin
      expItem_t e;
      e = sbQ.pop_front();
      checks++;
      if (segN !== e.seg || rippleOutN !== e.rbo) begin
        errors++;
        $display("FAIL %s: digit=%0d seg=%b rbo=%b expected seg=%b rbo=%b",
                 e.req, digit, segN, rippleOutN, e.seg, e.rbo);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    drive(4'd0, 1, 1, 1, "R1 idle after reset");
    for (int d = 0; d < 10; d++) drive(d[3:0], 1, 1, 1, "R1");
    for (int d = 10; d < 16; d++) drive(d[3:0], 1, 1, 1, "R2");
    drive(4'd0, 0, 1, 1, "R3");
    drive(4'd0, 0, 0, 1, "R3 over ripple");
    drive(4'd13, 0, 1, 1, "R3");
    drive(4'd0, 1, 0, 1, "R4");
    drive(4'd0, 1, 0, 1, "R5 low out");
    drive(4'd0, 1, 0, 0, "R5 with blank");
    drive(4'd0, 0, 0, 1, "R5 lamp keeps high");
    for (int d = 1; d < 16; d++) drive(d[3:0], 1, 0, 1, "R6");
    drive(4'd8, 0, 1, 0, "R7 over lamp");
    drive(4'd5, 1, 1, 0, "R7");
    drive(4'd0, 1, 0, 0, "R7 zero");
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: expected run end, got timeout");
    end
    if (sbQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sbQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule